// File: doc/BRIEF.md
# Dual Wiper Serial Control Port

This block is the digital front end of a dual 256-position digital potentiometer. A host drives a 3-wire serial port made of an enable line, a serial clock and a serial data line. While the enable line is high, each rising edge of the serial clock moves one data bit into a 17-bit frame register. When the enable line falls, the frame register is copied into the settings registers. These registers drive two 8-bit wiper codes and a stack-select flag to the analog array.

When a transaction opens, the frame register is first loaded with the current settings. The bits shifted out on the cascade output are therefore a readback of the current settings. Once the 17 old bits have left, the cascade output carries on with the host's own bits, so a second device on the same enable and clock lines can take its frame from the cascade output. The host sends one long stream, and the last 17 bits sent stay in the nearest device.

All port inputs are sampled on the system clock `clk`, which must run several times faster than the serial clock. The serial inputs are registered once, and edges are detected one system cycle later. Reset is synchronous and active high. The reset wiper code is the parameter `RESET_CODE` and the reset stack flag is the parameter `RESET_STACK`.

Top module: `wiper_serial_ctl`

## Requirements
- R1: After reset, both wiper outputs equal `RESET_CODE` (default 8'h80), `stack_sel` equals `RESET_STACK` (default 0), and `ser_cout` is 0.
- R2: While `ser_en` is low, `ser_clk` and `ser_din` have no effect: the wiper and stack outputs do not change and `ser_cout` stays 0.
- R3: A transaction opens only when `ser_en` goes from low to high. At that point the frame register is loaded with the current settings, and `ser_cout` shows the current `stack_sel` before any serial clock edge.
- R4: While a transaction is open, each rising edge of `ser_clk` shifts in exactly one bit from `ser_din`, and `ser_cout` changes only after such an edge or when the transaction opens or closes.
- R5: Frame layout in send order: bit 0 (sent first) is the stack flag. Bits 1 to 8 are the `wiper1` code, MSB first. Bits 9 to 16 are the `wiper0` code, MSB first.
- R6: `ser_cout` presents the bit that will leave the frame register on the next shift. The readback therefore comes out in the same order as R5 (stack, `wiper1` MSB..LSB, `wiper0` MSB..LSB), and after 17 shifts the bits that were shifted in earlier follow in the order they were sent.
- R7: The wiper and stack outputs change only when `ser_en` falls. At that point they take whatever the frame register holds: after n < 17 shifts, the last n bits sent fill frame positions 17-n to 16, and the old frame bits n to 16 fill positions 0 to 16-n. With no shifts, the settings are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial port enable; a transaction is open while it is high |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_cout | output | 1 | Cascade / readback data output, 0 while idle |
| wiper0 | output | 8 | Wiper code for potentiometer 0 |
| wiper1 | output | 8 | Wiper code for potentiometer 1 |
| stack_sel | output | 1 | Stack-select flag |

## Verification
The serial clock and data lines are toggled with the enable low, to show that an idle port touches neither the outputs nor the cascade line. Full 17-bit frames with asymmetric codes (A5/3C, 01/FE, FF/00) tell apart the MSB-first order, a swap of the two wiper fields and the position of the stack bit. Each of these frames also checks, bit by bit, the readback of the previous frame on the cascade output. A 5-bit partial frame shows how old and new bits merge when the enable falls early. A 34-bit stream shows pass-through for a daisy chain, and an enable pulse with no clock edges shows that an empty transaction keeps the settings.

// File: rtl/wiper_ctl_pkg.sv
package wiper_ctl_pkg;

    localparam int CODE_W  = 8;
    localparam int FRAME_W = 2 * CODE_W + 1;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic  stack;
        code_t code1;
        code_t code0;
    } settings_t;

    // Pack the settings in send order: stack, code1 MSB first, code0 MSB first
    function automatic frame_t to_frame(settings_t s);
        frame_t f;
        f[0] = s.stack;
        for (int i = 0; i < CODE_W; i++) begin
            f[1 + i]          = s.code1[CODE_W-1-i];
            f[1 + CODE_W + i] = s.code0[CODE_W-1-i];
        end
        return f;
    endfunction

    function automatic settings_t from_frame(frame_t f);
        settings_t s;
        s.stack = f[0];
        for (int i = 0; i < CODE_W; i++) begin
            s.code1[CODE_W-1-i] = f[1 + i];
            s.code0[CODE_W-1-i] = f[1 + CODE_W + i];
        end
        return s;
    endfunction

endpackage

// File: rtl/wctl_port_sampler.sv
module wctl_port_sampler (
    input  logic clk,
    input  logic rst,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic ser_din,
    output logic open_evt,
    output logic close_evt,
    output logic shift_evt,
    output logic shift_bit,
    output logic active
);
    logic en_r, en_d, sclk_r, sclk_d, din_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r   <= 1'b0;
            en_d   <= 1'b0;
            sclk_r <= 1'b0;
            sclk_d <= 1'b0;
            din_r  <= 1'b0;
        end else begin
            en_r   <= ser_en;
            en_d   <= en_r;
            sclk_r <= ser_clk;
            sclk_d <= sclk_r;
            din_r  <= ser_din;
        end
    end

    assign open_evt  = en_r & ~en_d;
    assign close_evt = ~en_r & en_d;
    assign shift_evt = en_r & en_d & sclk_r & ~sclk_d;
    assign shift_bit = din_r;
    assign active    = en_d;

endmodule

// File: rtl/wctl_frame_shifter.sv
module wctl_frame_shifter
    import wiper_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t load_val,
    input  logic   shift,
    input  logic   shift_bit,
    input  logic   active,
    output frame_t frame,
    output logic   cout
);
    frame_t sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {shift_bit, sr[FRAME_W-1:1]};
        end
    end

    assign frame = sr;
    assign cout  = active & sr[0];

endmodule

// File: rtl/wctl_setting_bank.sv
module wctl_setting_bank
    import wiper_ctl_pkg::*;
#(
    parameter code_t RESET_CODE  = 8'h80,
    parameter logic  RESET_STACK = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  frame_t    frame,
    output settings_t settings
);
    localparam settings_t RESET_SET = '{stack: RESET_STACK,
                                        code1: RESET_CODE,
                                        code0: RESET_CODE};

    always_ff @(posedge clk) begin
        if (rst) begin
            settings <= RESET_SET;
        end else if (commit) begin
            settings <= from_frame(frame);
        end
    end

endmodule

// File: rtl/wiper_serial_ctl.sv
module wiper_serial_ctl
    import wiper_ctl_pkg::*;
#(
    parameter code_t RESET_CODE  = 8'h80,
    parameter logic  RESET_STACK = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_en,
    input  logic        ser_clk,
    input  logic        ser_din,
    output logic        ser_cout,
    output logic [7:0]  wiper0,
    output logic [7:0]  wiper1,
    output logic        stack_sel
);
    logic      open_evt, close_evt, shift_evt, shift_bit, active;
    frame_t    frame;
    settings_t settings;

    wctl_port_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .ser_en    (ser_en),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .open_evt  (open_evt),
        .close_evt (close_evt),
        .shift_evt (shift_evt),
        .shift_bit (shift_bit),
        .active    (active)
    );

    wctl_frame_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (open_evt),
        .load_val  (to_frame(settings)),
        .shift     (shift_evt),
        .shift_bit (shift_bit),
        .active    (active),
        .frame     (frame),
        .cout      (ser_cout)
    );

    wctl_setting_bank #(
        .RESET_CODE  (RESET_CODE),
        .RESET_STACK (RESET_STACK)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit   (close_evt),
        .frame    (frame),
        .settings (settings)
    );

    assign wiper0    = settings.code0;
    assign wiper1    = settings.code1;
    assign stack_sel = settings.stack;

endmodule

// File: rtl/wiper_serial_ctl_chk.sv
module wiper_serial_ctl_chk #(
    parameter logic [7:0] RESET_CODE  = 8'h80,
    parameter logic       RESET_STACK = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       ser_en,
    input logic       ser_clk,
    input logic       ser_cout,
    input logic [7:0] wiper0,
    input logic [7:0] wiper1,
    input logic       stack_sel
);
    logic en_p1, en_p2, ck_p1, ck_p2;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_p1 <= 1'b0;
            en_p2 <= 1'b0;
            ck_p1 <= 1'b0;
            ck_p2 <= 1'b0;
        end else begin
            en_p1 <= ser_en;
            en_p2 <= en_p1;
            ck_p1 <= ser_clk;
            ck_p2 <= ck_p1;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (wiper0 == RESET_CODE && wiper1 == RESET_CODE &&
                 stack_sel == RESET_STACK && ser_cout == 1'b0));

    // R2
    idle_cout_chk: assert property (@(posedge clk) disable iff (rst)
        !en_p2 |-> (ser_cout == 1'b0));

    // R3
    load_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (en_p1 && !en_p2) |=> (ser_cout == stack_sel));

    // R4
    cout_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (en_p1 && en_p2 && !(ck_p1 && !ck_p2)) |=> $stable(ser_cout));

    // R7
    settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(en_p2 && !en_p1) |=> ($stable(wiper0) && $stable(wiper1) && $stable(stack_sel)));

endmodule

bind wiper_serial_ctl wiper_serial_ctl_chk #(
    .RESET_CODE  (RESET_CODE),
    .RESET_STACK (RESET_STACK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_en    (ser_en),
    .ser_clk   (ser_clk),
    .ser_cout  (ser_cout),
    .wiper0    (wiper0),
    .wiper1    (wiper1),
    .stack_sel (stack_sel)
);

// File: tb/wiper_serial_ctl_bench.sv
module wiper_serial_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_cout;
    logic [7:0] wiper0, wiper1;
    logic       stack_sel;

    always #4 clk = ~clk;

    wiper_serial_ctl u_wiper_serial_ctl (
        .clk       (clk),
        .rst       (rst),
        .ser_en    (ser_en),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_cout  (ser_cout),
        .wiper0    (wiper0),
        .wiper1    (wiper1),
        .stack_sel (stack_sel)
    );

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] w0;
        logic [7:0] w1;
        logic       st;
        string      tag;
    } exp_set_t;

    logic     exp_cout_q[$];
    string    cout_tag_q[$];
    exp_set_t set_q[$];
    logic [16:0] cur;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Frame in send order: [0]=stack, [1..8]=wiper1 MSB first, [9..16]=wiper0 MSB first (R5)
    function automatic logic [16:0] mk(input logic st, input logic [7:0] w1,
                                       input logic [7:0] w0);
        logic [16:0] f;
        f[0] = st;
        for (int i = 0; i < 8; i++) begin
            f[1 + i] = w1[7 - i];
            f[9 + i] = w0[7 - i];
        end
        return f;
    endfunction

    function automatic exp_set_t unpack(input logic [16:0] f, input string tag);
        exp_set_t e;
        e.st  = f[0];
        e.tag = tag;
        for (int i = 0; i < 8; i++) begin
            e.w1[7 - i] = f[1 + i];
            e.w0[7 - i] = f[9 + i];
        end
        return e;
    endfunction

    // Monitor: cascade output ahead of each serial rising edge (R3, R6)
    always @(posedge ser_clk) begin
        logic  e;
        string t;
        if (ser_en && exp_cout_q.size() > 0) begin
            e = exp_cout_q.pop_front();
            t = cout_tag_q.pop_front();
            check(ser_cout === e, t, "ser_cout", ser_cout, e);
        end
    end

    // Monitor: settings after each enable fall (R7)
    initial begin
        forever begin
            @(negedge ser_en);
            if (set_q.size() > 0) begin
                exp_set_t e;
                repeat (4) @(negedge clk);
                e = set_q.pop_front();
                check(wiper0 === e.w0, e.tag, "wiper0", wiper0, e.w0);
                check(wiper1 === e.w1, e.tag, "wiper1", wiper1, e.w1);
                check(stack_sel === e.st, e.tag, "stack_sel", stack_sel, e.st);
            end
        end
    end

    // Driver: one transaction of n bits, bits[0] sent first
    task automatic xfer(input logic [63:0] bits, input int n, input string tag);
        logic [16:0] m;
        exp_set_t    old;
        m   = cur;
        old = unpack(cur, tag);
        @(negedge clk);
        ser_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            exp_cout_q.push_back(m[0]);
            cout_tag_q.push_back(tag);
            m = {bits[i], m[16:1]};
            ser_din = bits[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            if (i == 8) begin
                // R7: no change while the frame is only partly shifted
                check(wiper0 === old.w0, "R7", "wiper0 mid-frame", wiper0, old.w0);
                check(wiper1 === old.w1, "R7", "wiper1 mid-frame", wiper1, old.w1);
            end
        end
        cur = m;
        set_q.push_back(unpack(m, tag));
        repeat (2) @(negedge clk);
        ser_en = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        cur = mk(1'b0, 8'h80, 8'h80);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(wiper0 === 8'h80, "R1", "wiper0 reset", wiper0, 8'h80);
        check(wiper1 === 8'h80, "R1", "wiper1 reset", wiper1, 8'h80);
        check(stack_sel === 1'b0, "R1", "stack_sel reset", stack_sel, 0);
        check(ser_cout === 1'b0, "R1", "ser_cout reset", ser_cout, 0);

        // R2: idle port ignores clock and data
        for (int k = 0; k < 5; k++) begin
            ser_din = k[0];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            check(ser_cout === 1'b0, "R2", "ser_cout idle", ser_cout, 0);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        check(wiper0 === 8'h80, "R2", "wiper0 idle", wiper0, 8'h80);
        check(wiper1 === 8'h80, "R2", "wiper1 idle", wiper1, 8'h80);
        check(stack_sel === 1'b0, "R2", "stack_sel idle", stack_sel, 0);

        xfer({47'd0, mk(1'b1, 8'hA5, 8'h3C)}, 17, "R5");
        xfer({47'd0, mk(1'b0, 8'h01, 8'hFE)}, 17, "R6");
        xfer({47'd0, mk(1'b1, 8'hFF, 8'h00)}, 17, "R4");
        xfer({59'd0, 5'b10110}, 5, "R7");
        xfer({30'd0, mk(1'b1, 8'h12, 8'h34), mk(1'b0, 8'h5A, 8'h81)}, 34, "R6");
        xfer(64'd0, 0, "R3");
        xfer({47'd0, mk(1'b0, 8'hC3, 8'h7E)}, 17, "R3");

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule